// File: doc/BRIEF.md
# Splittable Timer/Counter with Capture

This block is a 16-bit counter that a two-bit mode field can run as one wide counter or as two independent 8-bit halves. Each half either counts prescaled clock cycles or counts rising edges of an external event input. Each of the two prescalers divides the system clock by a programmable value plus one. A half that reaches its programmed match value wraps back to zero on its next increment and raises a sticky flag. Two capture strobes copy the running count into read-back registers. In the 16-bit modes the low strobe copies the full width.

Software configures the block through a byte-wide write port. Address 0 sets the mode from data bits [1:0]. Addresses 1 and 2 set the low and high prescale limits. Addresses 3 and 4 set the low and high match values. Address 5 clears flags: bit 0 clears the low flag and bit 1 clears the high flag. Writes to other addresses are ignored. The event input and both capture strobes are asynchronous levels. Each one passes through a two-flop synchroniser, and each of its rising edges produces exactly one internal pulse.

Top module: `splittable_timer`

## Requirements
- R1: After reset both capture registers read 0, both flags are low, the mode is 0, both prescale limits are 0, and both match values are all ones.
- R2: A prescaler with limit P issues one count enable every P+1 clock cycles, so a limit of 0 gives one every cycle. After a mode write the low count reads floor(n/(P+1)) n cycles later. If the limit is lowered below the running prescale count, the next cycle issues an enable.
- R3: In the 8-bit modes a half counts 0,1,..,M. On the increment that finds the count equal to its match value M, the half reloads to 0 and sets its flag. The flag stays high until a write to address 5 with the matching data bit set. If a flag sets and clears in the same cycle, the set wins.
- R4: Mode 0 runs both halves as prescaled timers, each with its own prescale limit and match value.
- R5: Mode 1 runs the low half as a prescaled timer and the high half as a counter of event-input rising edges. The high prescale limit has no effect in this mode.
- R6: Mode 2 runs one 16-bit timer driven by the low prescaler. Its match value is {high match, low match}. On wrap it sets the high flag, and the low flag stays low.
- R7: Mode 3 runs one 16-bit counter of event-input rising edges. Its match value and flag behave as in R6.
- R8: The event input and the capture inputs are synchronised by two flops and edge-detected. Each rising edge acts exactly once, whatever its length, two clock edges after the edge that first samples it high.
- R9: In the 8-bit modes the low strobe copies the low count into the low capture register, and the high strobe copies the high count into the high capture register, independently. The value copied is the count held just before that cycle's increment.
- R10: In the 16-bit modes the low strobe copies all 16 bits, with the high byte going to the high capture register. The high strobe has no effect.
- R11: A mode write clears both counts, both prescalers and both flags, and leaves the capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0 mode, 1/2 prescale, 3/4 match, 5 flag clear) |
| wr_data | input | 8 | Register write data |
| evt_in | input | 1 | External event input, asynchronous |
| cap_lo_in | input | 1 | Low-half capture strobe, asynchronous |
| cap_hi_in | input | 1 | High-half capture strobe, asynchronous |
| cap_lo_q | output | 8 | Low capture register |
| cap_hi_q | output | 8 | High capture register |
| flag_lo | output | 1 | Sticky match flag of the low half |
| flag_hi | output | 1 | Sticky match flag of the high half, or of the wide counter |

## Verification
The main function runs in all four modes. The event input takes a random level each cycle, the prescale limits range from 0 to 3, the match values are small, and the capture strobes and flag-clear writes are sparse. A cycle model compares every capture value and flag, and the comparison shows whether each half takes its enables from the right prescaler or from the event input. Directed cases pin the synchroniser latency with a capture that must read exactly 2. They also pin the divide-by-limit-plus-one rule with a capture that must read floor(11/4). Further directed cases show that the high strobe is ignored in a wide mode while the high count is nonzero, and test flag stickiness and clearing as well as how a mode write treats flags and captures.

// File: rtl/stmr_pkg.sv
package stmr_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT_TT = 2'd0,
        MODE_SPLIT_TE = 2'd1,
        MODE_WIDE_T   = 2'd2,
        MODE_WIDE_E   = 2'd3
    } mode_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE     = 3'd0;
    localparam logic [ADDR_W-1:0] A_PSC_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PSC_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MAT_LO   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MAT_HI   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG_CLR = 3'd5;

    typedef struct packed {
        logic mode_wr;
        logic psc_lo_wr;
        logic psc_hi_wr;
        logic mat_lo_wr;
        logic mat_hi_wr;
        logic clr_lo;
        logic clr_hi;
    } wr_strobe_t;

    function automatic logic is_wide(mode_t m);
        return m[1];
    endfunction

    function automatic logic high_counts_events(mode_t m);
        return m == MODE_SPLIT_TE;
    endfunction

endpackage

// File: rtl/stmr_edge_sync.sv
module stmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] shreg;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            last  <= 1'b0;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
            last  <= shreg[STAGES-1];
        end
    end

    assign rise = shreg[STAGES-1] & ~last;
endmodule

// File: rtl/stmr_prescaler.sv
module stmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    // a limit lowered under the running count still wraps at once
    assign tick = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stmr_regs.sv
module stmr_regs
    import stmr_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int PSC_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_q,
    output logic [PSC_W-1:0]  psc_lo,
    output logic [PSC_W-1:0]  psc_hi,
    output logic [HALF_W-1:0] mat_lo,
    output logic [HALF_W-1:0] mat_hi,
    output wr_strobe_t        stb
);
    always_comb begin
        stb           = '0;
        stb.mode_wr   = wr_en && (wr_addr == A_MODE);
        stb.psc_lo_wr = wr_en && (wr_addr == A_PSC_LO);
        stb.psc_hi_wr = wr_en && (wr_addr == A_PSC_HI);
        stb.mat_lo_wr = wr_en && (wr_addr == A_MAT_LO);
        stb.mat_hi_wr = wr_en && (wr_addr == A_MAT_HI);
        stb.clr_lo    = wr_en && (wr_addr == A_FLAG_CLR) && wr_data[0];
        stb.clr_hi    = wr_en && (wr_addr == A_FLAG_CLR) && wr_data[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SPLIT_TT;
            psc_lo <= '0;
            psc_hi <= '0;
            mat_lo <= '1;
            mat_hi <= '1;
        end else begin
            if (stb.mode_wr)   mode_q <= mode_t'(wr_data[1:0]);
            if (stb.psc_lo_wr) psc_lo <= wr_data[PSC_W-1:0];
            if (stb.psc_hi_wr) psc_hi <= wr_data[PSC_W-1:0];
            if (stb.mat_lo_wr) mat_lo <= wr_data[HALF_W-1:0];
            if (stb.mat_hi_wr) mat_hi <= wr_data[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/splittable_timer.sv
module splittable_timer
    import stmr_pkg::*;
#(
    parameter int HALF_W    = 8,
    parameter int PSC_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [((HALF_W > PSC_W) ? HALF_W : PSC_W)-1:0] wr_data,
    input  logic                  evt_in,
    input  logic                  cap_lo_in,
    input  logic                  cap_hi_in,
    output logic [HALF_W-1:0]     cap_lo_q,
    output logic [HALF_W-1:0]     cap_hi_q,
    output logic                  flag_lo,
    output logic                  flag_hi
);
    localparam int DATA_W = (HALF_W > PSC_W) ? HALF_W : PSC_W;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int N_IN   = 3;
    localparam int N_PSC  = 2;

    mode_t             mode_q;
    logic [PSC_W-1:0]  psc_lo, psc_hi;
    logic [HALF_W-1:0] mat_lo, mat_hi;
    wr_strobe_t        stb;

    stmr_regs #(.HALF_W(HALF_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_q(mode_q), .psc_lo(psc_lo), .psc_hi(psc_hi),
        .mat_lo(mat_lo), .mat_hi(mat_hi), .stb(stb)
    );

    // input conditioning: index 0 event, 1 low strobe, 2 high strobe
    logic [N_IN-1:0] pins, rises;
    assign pins = {cap_hi_in, cap_lo_in, evt_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        stmr_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
            .clk(clk), .rst(rst), .din(pins[i]), .rise(rises[i])
        );
    end

    logic ev_p, cap_lo_p, cap_hi_p;
    assign ev_p     = rises[0];
    assign cap_lo_p = rises[1];
    assign cap_hi_p = rises[2];

    // prescalers: index 0 low half (also the wide timer), 1 high half
    logic [PSC_W-1:0] psc_lim [N_PSC];
    logic [N_PSC-1:0] tick;
    assign psc_lim[0] = psc_lo;
    assign psc_lim[1] = psc_hi;

    for (genvar h = 0; h < N_PSC; h++) begin : g_psc
        stmr_prescaler #(.W(PSC_W)) u_psc (
            .clk(clk), .rst(rst), .clr(stb.mode_wr),
            .limit(psc_lim[h]), .tick(tick[h])
        );
    end

    // count enables per mode
    logic wide, inc_lo, inc_hi, inc_wide;
    assign wide     = is_wide(mode_q);
    assign inc_lo   = tick[0];
    assign inc_hi   = high_counts_events(mode_q) ? ev_p : tick[1];
    assign inc_wide = (mode_q == MODE_WIDE_T) ? tick[0] : ev_p;

    logic [HALF_W-1:0] cnt_lo, cnt_hi, cnt_lo_nx, cnt_hi_nx;
    logic [HALF_W-1:0] cap_lo_nx, cap_hi_nx;
    logic              flag_lo_nx, flag_hi_nx;
    logic [CNT_W-1:0]  cnt_w, mat_w;

    assign cnt_w = {cnt_hi, cnt_lo};
    assign mat_w = {mat_hi, mat_lo};

    always_comb begin
        cnt_lo_nx  = cnt_lo;
        cnt_hi_nx  = cnt_hi;
        flag_lo_nx = flag_lo & ~stb.clr_lo;
        flag_hi_nx = flag_hi & ~stb.clr_hi;
        cap_lo_nx  = cap_lo_q;
        cap_hi_nx  = cap_hi_q;

        // capture takes the count held before this cycle's increment
        if (cap_lo_p) begin
            cap_lo_nx = cnt_lo;
            if (wide) cap_hi_nx = cnt_hi;
        end
        if (cap_hi_p && !wide) cap_hi_nx = cnt_hi;

        if (stb.mode_wr) begin
            cnt_lo_nx  = '0;
            cnt_hi_nx  = '0;
            flag_lo_nx = 1'b0;
            flag_hi_nx = 1'b0;
        end else if (wide) begin
            if (inc_wide) begin
                if (cnt_w == mat_w) begin
                    {cnt_hi_nx, cnt_lo_nx} = '0;
                    flag_hi_nx = 1'b1;
                end else begin
                    {cnt_hi_nx, cnt_lo_nx} = cnt_w + 1'b1;
                end
            end
        end else begin
            if (inc_lo) begin
                if (cnt_lo == mat_lo) begin
                    cnt_lo_nx  = '0;
                    flag_lo_nx = 1'b1;
                end else begin
                    cnt_lo_nx = cnt_lo + 1'b1;
                end
            end
            if (inc_hi) begin
                if (cnt_hi == mat_hi) begin
                    cnt_hi_nx  = '0;
                    flag_hi_nx = 1'b1;
                end else begin
                    cnt_hi_nx = cnt_hi + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            flag_lo  <= 1'b0;
            flag_hi  <= 1'b0;
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            cnt_lo   <= cnt_lo_nx;
            cnt_hi   <= cnt_hi_nx;
            flag_lo  <= flag_lo_nx;
            flag_hi  <= flag_hi_nx;
            cap_lo_q <= cap_lo_nx;
            cap_hi_q <= cap_hi_nx;
        end
    end
endmodule

// File: rtl/stmr_checker.sv
module stmr_checker #(
    parameter int HALF_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        mode_q,
    input logic              ev_p,
    input logic              cap_lo_p,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cap_lo_q,
    input logic [HALF_W-1:0] cap_hi_q,
    input logic              flag_lo,
    input logic              flag_hi
);
    // R1: the cycle after reset everything visible is cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!flag_lo && !flag_hi && cap_lo_q == '0 && cap_hi_q == '0));

    // R3: a low flag holds unless cleared or a mode write occurs
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_lo && !(wr_en && (wr_addr == 3'd0 || (wr_addr == 3'd5 && wr_data[0]))))
        |=> flag_lo);

    // R5: the event-driven high half moves only on an event pulse
    a_r5_hi_event_only: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1 && !ev_p && !wr_en) |=> $stable(cnt_hi));

    // R6: the low flag is never raised in a wide mode
    a_r6_no_lo_flag_wide: assert property (@(posedge clk) disable iff (rst)
        mode_q[1] |-> !flag_lo);

    // R7: the wide event counter is frozen without an event pulse
    a_r7_wide_event_only: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3 && !ev_p && !wr_en) |=> $stable({cnt_hi, cnt_lo}));

    // R10: in a wide mode the high capture only follows a low strobe
    a_r10_hi_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1] && !cap_lo_p) |=> $stable(cap_hi_q));
endmodule

bind splittable_timer stmr_checker #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .ev_p(ev_p), .cap_lo_p(cap_lo_p),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q),
    .flag_lo(flag_lo), .flag_hi(flag_hi)
);

// File: tb/splittable_timer_test.sv
`timescale 1ns/1ps
module splittable_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       evt_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
    logic [7:0] cap_lo_q, cap_hi_q;
    logic       flag_lo, flag_hi;

    int checks = 0;
    int errors = 0;
    logic cmp_on = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    splittable_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_in(evt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
        .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q), .flag_lo(flag_lo), .flag_hi(flag_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // reference model of the requirements, advanced once per clock
    logic [2:0] ms1, ms2, ms3;
    logic [1:0] mmode;
    logic [7:0] mpl, mph, mml, mmh, mpc0, mpc1, mcl, mch, mkl, mkh;
    logic       mfl, mfh;

    always @(posedge clk) begin : model
        logic pe, pl, ph, t0, t1, wd, ih, iw;
        logic [15:0] w;
        if (rst) begin
            ms1 = 0; ms2 = 0; ms3 = 0; mmode = 0; mpl = 0; mph = 0;
            mml = 8'hFF; mmh = 8'hFF; mpc0 = 0; mpc1 = 0;
            mcl = 0; mch = 0; mkl = 0; mkh = 0; mfl = 0; mfh = 0;
        end else begin
            pe = ms2[0] & ~ms3[0];
            pl = ms2[1] & ~ms3[1];
            ph = ms2[2] & ~ms3[2];
            t0 = (mpc0 >= mpl);
            t1 = (mpc1 >= mph);
            wd = mmode[1];
            if (pl) begin
                mkl = mcl;
                if (wd) mkh = mch;
            end
            if (ph && !wd) mkh = mch;
            if (wr_en && wr_addr == 3'd5) begin
                if (wr_data[0]) mfl = 1'b0;
                if (wr_data[1]) mfh = 1'b0;
            end
            mpc0 = t0 ? 8'd0 : mpc0 + 8'd1;
            mpc1 = t1 ? 8'd0 : mpc1 + 8'd1;
            if (wr_en && wr_addr == 3'd0) begin
                mcl = 0; mch = 0; mfl = 0; mfh = 0; mpc0 = 0; mpc1 = 0;
            end else if (wd) begin
                iw = (mmode == 2'd2) ? t0 : pe;
                w  = {mch, mcl};
                if (iw) begin
                    if (w == {mmh, mml}) begin
                        w = 16'd0;
                        mfh = 1'b1;
                    end else begin
                        w = w + 16'd1;
                    end
                end
                {mch, mcl} = w;
            end else begin
                ih = (mmode == 2'd0) ? t1 : pe;
                if (t0) begin
                    if (mcl == mml) begin mcl = 0; mfl = 1'b1; end
                    else mcl = mcl + 8'd1;
                end
                if (ih) begin
                    if (mch == mmh) begin mch = 0; mfh = 1'b1; end
                    else mch = mch + 8'd1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: mmode = wr_data[1:0];
                    3'd1: mpl = wr_data;
                    3'd2: mph = wr_data;
                    3'd3: mml = wr_data;
                    3'd4: mmh = wr_data;
                    default: ;
                endcase
            end
            ms3 = ms2;
            ms2 = ms1;
            ms1 = {cap_hi_in, cap_lo_in, evt_in};
        end
    end

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'd0:    return "R4,R9,R3 model";
            2'd1:    return "R5,R9,R3 model";
            2'd2:    return "R6,R10 model";
            default: return "R7,R10,R8 model";
        endcase
    endfunction

    always @(negedge clk) begin
        if (cmp_on)
            chk(mtag(mmode), 32'({cap_hi_q, cap_lo_q, flag_hi, flag_lo}),
                32'({mkh, mkl, mfh, mfl}));
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] kl, kh;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 captures", 32'({cap_hi_q, cap_lo_q}), 32'h0);
        chk("R1 flags", 32'({flag_hi, flag_lo}), 32'h0);
        cmp_on = 1'b1;

        // R2: limit 3, low count after n cycles is floor(n/4)
        wr(3'd1, 8'd3);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'd0);
        repeat (9) @(negedge clk);
        cap_lo_in = 1'b1;
        repeat (3) @(negedge clk);
        cap_lo_in = 1'b0;
        chk("R2 divide by limit plus one", 32'(cap_lo_q), 32'd2);

        // R8 and R10: two-flop latency, wide capture of the full count
        wr(3'd1, 8'd0);
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'd2);
        cap_lo_in = 1'b1;
        repeat (3) @(negedge clk);
        cap_lo_in = 1'b0;
        chk("R8 capture latency", 32'(cap_lo_q), 32'd2);
        chk("R10 wide capture high byte", 32'(cap_hi_q), 32'd0);
        repeat (300) @(negedge clk);
        cap_hi_in = 1'b1;
        repeat (4) @(negedge clk);
        cap_hi_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 high strobe ignored in wide mode", 32'(cap_hi_q), 32'd0);

        // R3: match 2 wraps on the third increment, flag sticky, then cleared
        wr(3'd3, 8'd2);
        wr(3'd0, 8'd0);
        repeat (2) @(negedge clk);
        chk("R3 flag before wrap", 32'(flag_lo), 32'd0);
        @(negedge clk);
        chk("R3 flag on wrap", 32'(flag_lo), 32'd1);
        wr(3'd3, 8'hFF);
        chk("R3 flag sticky", 32'(flag_lo), 32'd1);
        wr(3'd5, 8'd1);
        chk("R3 flag cleared", 32'(flag_lo), 32'd0);

        // R11: mode write clears flags, keeps captures
        wr(3'd3, 8'd1);
        wr(3'd0, 8'd0);
        repeat (4) @(negedge clk);
        chk("R11 setup flag", 32'(flag_lo), 32'd1);
        kl = cap_lo_q;
        kh = cap_hi_q;
        wr(3'd0, 8'd1);
        chk("R11 flags cleared", 32'({flag_hi, flag_lo}), 32'h0);
        chk("R11 captures kept", 32'({cap_hi_q, cap_lo_q}), 32'({kh, kl}));

        // random phases in every mode
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                wr(3'd1, 8'($urandom_range(0, 3)));
                wr(3'd2, 8'($urandom_range(0, 3)));
                wr(3'd3, 8'($urandom_range(0, 12)));
                wr(3'd4, (m > 1) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 12)));
                wr(3'd0, 8'(m));
                for (int c = 0; c < 300; c++) begin
                    evt_in    = 1'($urandom_range(0, 1));
                    cap_lo_in = ($urandom_range(0, 15) == 0);
                    cap_hi_in = ($urandom_range(0, 15) == 0);
                    if ($urandom_range(0, 31) == 0) wr(3'd5, 8'($urandom_range(0, 3)));
                    else @(negedge clk);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule